// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Controller

This block gathers ten interrupt request lines and presents at most one of them to a processor as a vectored request. Each line owns a pending latch and an enable bit. Each line also has a one-bit tier selector. Selector value 0 puts the line in the low tier. Selector value 1 lifts it to the top tier on the first two lines and to the middle tier on the other eight. The request, the winning vector address and its tier are registered outputs.

The processor pulses `ack_i` for one cycle when it enters the handler named on the outputs. The controller then records that tier as in service. While a tier is recorded, requests at that tier and at any tier below it are held back. The processor pulses `ret_i` when a handler exits, and this removes the most senior recorded tier. The request, acknowledge and return pins are plain control signals: there is no valid/ready pairing at the edge. An acknowledge has effect only while `req_o` is high.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset `req_o` is 0, `vec_o` is 0, `lvl_o` is 0 and no tier is in service, so the first request at any tier is accepted.
- R2: Line i (0 to 9) is reported with the vector address 03h + 8*i, from 03h for line 0 to 4Bh for line 9.
- R3: `lvl_o` uses code 0 for low, 1 for high and 2 for highest. A `lvl_sel_i` bit of 0 makes its line low. A bit of 1 makes lines 0 and 1 highest and makes lines 2 to 9 high. Code 1 never appears for lines 0 and 1, and code 2 never appears for lines 2 to 9.
- R4: Among competing lines, the one with the greater tier wins.
- R5: Among competing lines of equal tier, the lowest line index (the lowest vector address) wins.
- R6: A one-cycle high on `irq_i[i]` sets the pending latch of line i. The latch holds until that line is acknowledged, and the acknowledge clears it.
- R7: A line whose `en_i` bit is 0 never wins, but it keeps its pending latch. Once the bit is set, the line competes again.
- R8: While tiers are in service, a line is refused unless its tier is above every tier in service.
- R9: `ret_i` removes the most senior tier in service, so lower handlers regain their threshold. `ret_i` with nothing in service has no effect.
- R10: On the edge that samples `ack_i` with `req_o` high, `req_o` falls and `vec_o`/`lvl_o` hold their value. The outputs are recomputed on the next edge. `ack_i` while `req_o` is 0 has no effect.
- R11: A request pulse sampled on edge k shows on `req_o`/`vec_o`/`lvl_o` after edge k+1 (two registers deep).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | 10 | Request pulses, one per line, which set the pending latches |
| en_i | input | 10 | Per-line enable for arbitration |
| lvl_sel_i | input | 10 | Per-line tier selector (0 low, 1 elevated) |
| ack_i | input | 1 | Handler entry pulse for the presented vector |
| ret_i | input | 1 | Handler exit pulse |
| req_o | output | 1 | Vectored request to the processor |
| vec_o | output | 8 | Vector address of the winner |
| lvl_o | output | 2 | Tier of the winner (0 low, 1 high, 2 highest) |

## Verification
The bench builds the block with its defaults: ten lines, two lines that may use the top tier, base 03h and step 8, on an 8-bit vector. These values reach the full address span up to 4Bh and put lines of both tier classes into the same contest. Nesting is exercised two handlers deep, with refused requests released again as returns unwind the record of tiers in service.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_HIGH = 2'd1,
    LVL_TOP  = 2'd2
  } lvl_e;

  localparam int NUM_TIERS = 3;

  // one-hot bit of a tier in the in-service record
  function automatic logic [NUM_TIERS-1:0] tier_bit(input logic [1:0] l);
    return NUM_TIERS'(1) << l;
  endfunction

  // mask of record bits at or above a tier
  function automatic logic [NUM_TIERS-1:0] tier_at_or_above(input logic [1:0] l);
    return ~((NUM_TIERS'(1) << l) - NUM_TIERS'(1));
  endfunction
endpackage

// File: rtl/irqc_pend_bank.sv
module irqc_pend_bank #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_o[g] <= 1'b0;
      else        pend_o[g] <= (pend_o[g] & ~clr_i[g]) | set_i[g];
    end
  end
endmodule

// File: rtl/irqc_level_map.sv
module irqc_level_map
  import irqc_pkg::*;
#(
  parameter int N        = 10,
  parameter int TOP_LINES = 2
) (
  input  logic [N-1:0]      sel_i,
  output logic [N-1:0][1:0] lvl_o
);
  for (genvar g = 0; g < N; g++) begin : g_map
    if (g < TOP_LINES) begin : g_top
      assign lvl_o[g] = sel_i[g] ? LVL_TOP : LVL_LOW;
    end else begin : g_mid
      assign lvl_o[g] = sel_i[g] ? LVL_HIGH : LVL_LOW;
    end
  end
endmodule

// File: rtl/irqc_nest_stack.sv
module irqc_nest_stack
  import irqc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push_i,
  input  logic [1:0]           push_lvl_i,
  input  logic                 pop_i,
  output logic [NUM_TIERS-1:0] ins_o
);
  logic [NUM_TIERS-1:0] senior;
  logic [NUM_TIERS-1:0] after_pop;

  always_comb begin
    senior = '0;
    for (int t = 0; t < NUM_TIERS; t++) begin
      if (ins_o[t]) senior = NUM_TIERS'(1) << t;
    end
    after_pop = pop_i ? (ins_o & ~senior) : ins_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ins_o <= '0;
    else        ins_o <= after_pop | (push_i ? tier_bit(push_lvl_i) : '0);
  end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
#(
  parameter int N     = 10,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]         cand_i,
  input  logic [N-1:0][1:0]    lvl_i,
  input  logic [NUM_TIERS-1:0] ins_i,
  output logic                 win_vld_o,
  output logic [IDX_W-1:0]     win_idx_o,
  output logic [1:0]           win_lvl_o
);
  logic [N-1:0] elig;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      elig[i] = cand_i[i] & ~|(ins_i & tier_at_or_above(lvl_i[i]));
    end
  end

  // scan from the top index down; ">=" lets a lower index take a tie
  always_comb begin
    win_vld_o = 1'b0;
    win_idx_o = '0;
    win_lvl_o = LVL_LOW;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i] && (!win_vld_o || lvl_i[i] >= win_lvl_o)) begin
        win_vld_o = 1'b1;
        win_idx_o = IDX_W'(i);
        win_lvl_o = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irqc_pkg::*;
#(
  parameter int N         = 10,
  parameter int TOP_LINES = 2,
  parameter int VEC_W     = 8,
  parameter int VEC_BASE  = 3,
  parameter int VEC_STEP  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     irq_i,
  input  logic [N-1:0]     en_i,
  input  logic [N-1:0]     lvl_sel_i,
  input  logic             ack_i,
  input  logic             ret_i,
  output logic             req_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [1:0]       lvl_o
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]         pend;
  logic [N-1:0]         clr;
  logic [N-1:0][1:0]    line_lvl;
  logic [NUM_TIERS-1:0] ins_w;
  logic                 win_vld;
  logic [IDX_W-1:0]     win_idx;
  logic [1:0]           win_lvl;
  logic [IDX_W-1:0]     idx_q;
  logic                 ack_take;

  assign ack_take = ack_i & req_o;
  assign clr      = ack_take ? (N'(1) << idx_q) : '0;

  irqc_pend_bank #(.N(N)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(irq_i), .clr_i(clr), .pend_o(pend)
  );

  irqc_level_map #(.N(N), .TOP_LINES(TOP_LINES)) u_map (
    .sel_i(lvl_sel_i), .lvl_o(line_lvl)
  );

  irqc_nest_stack u_nest (
    .clk(clk), .rst_n(rst_n), .push_i(ack_take), .push_lvl_i(lvl_o),
    .pop_i(ret_i), .ins_o(ins_w)
  );

  irqc_arbiter #(.N(N)) u_arb (
    .cand_i(pend & en_i), .lvl_i(line_lvl), .ins_i(ins_w),
    .win_vld_o(win_vld), .win_idx_o(win_idx), .win_lvl_o(win_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_o <= 1'b0;
      vec_o <= '0;
      lvl_o <= LVL_LOW;
      idx_q <= '0;
    end else if (ack_take) begin
      req_o <= 1'b0;
    end else begin
      req_o <= win_vld;
      if (win_vld) begin
        vec_o <= VEC_W'(VEC_BASE + int'(win_idx) * VEC_STEP);
        lvl_o <= win_lvl;
        idx_q <= win_idx;
      end
    end
  end
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk
  import irqc_pkg::*;
#(
  parameter int N         = 10,
  parameter int TOP_LINES = 2,
  parameter int VEC_W     = 8,
  parameter int VEC_BASE  = 3,
  parameter int VEC_STEP  = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ack_i,
  input logic                 ret_i,
  input logic                 req_o,
  input logic [VEC_W-1:0]     vec_o,
  input logic [1:0]           lvl_o,
  input logic [NUM_TIERS-1:0] ins_w
);
  int off;
  int line;
  assign off  = int'(vec_o) - VEC_BASE;
  assign line = off / VEC_STEP;

  // R2
  vec_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (off >= 0 && off % VEC_STEP == 0 && line < N));

  // R3
  tier_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> ((line < TOP_LINES) ? (lvl_o != LVL_HIGH) : (lvl_o != LVL_TOP)));

  // R10
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && req_o) |=> (!req_o && $stable(vec_o) && $stable(lvl_o)));

  // R8
  ack_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && req_o) |=> ins_w[$past(lvl_o)]);

  // R9
  no_silent_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_i |=> ((ins_w & $past(ins_w)) == $past(ins_w)));

  // R10
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !req_o && !ret_i) |=> $stable(ins_w));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(
  .N(N), .TOP_LINES(TOP_LINES), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .ret_i(ret_i),
  .req_o(req_o), .vec_o(vec_o), .lvl_o(lvl_o), .ins_w(ins_w)
);

// File: tb/irq_vec_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vec_ctrl_tb;
  localparam int N = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_i = '0, en_i = '1, lvl_sel_i = '0;
  logic ack_i = 1'b0, ret_i = 1'b0;
  logic req_o;
  logic [7:0] vec_o;
  logic [1:0] lvl_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  irq_vec_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .en_i(en_i), .lvl_sel_i(lvl_sel_i),
    .ack_i(ack_i), .ret_i(ret_i), .req_o(req_o), .vec_o(vec_o), .lvl_o(lvl_o)
  );

  typedef struct packed {
    logic [N-1:0] irq;
    logic [N-1:0] sel;
    logic [7:0]   vec;
    logic [1:0]   lvl;
  } row_t;

  localparam row_t TBL [8] = '{
    '{10'h010, 10'h000, 8'h23, 2'd0},  // R2 single low line
    '{10'h088, 10'h000, 8'h1B, 2'd0},  // R5 tie at low
    '{10'h088, 10'h080, 8'h3B, 2'd1},  // R4 high beats lower index
    '{10'h201, 10'h200, 8'h4B, 2'd1},  // R4 last vector high
    '{10'h006, 10'h006, 8'h0B, 2'd2},  // R3 highest over high
    '{10'h003, 10'h003, 8'h03, 2'd2},  // R5 tie at highest
    '{10'h3FC, 10'h000, 8'h13, 2'd0},  // R5 eight low lines
    '{10'h3FC, 10'h100, 8'h43, 2'd1}   // R4 one high among lows
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse_irq(input logic [N-1:0] m);
    irq_i = m;
    @(negedge clk);
    irq_i = '0;
  endtask

  task automatic do_ack();
    ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
  endtask

  task automatic do_ret();
    ret_i = 1'b1;
    @(negedge clk);
    ret_i = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    for (int k = 0; k < 16 && req_o; k++) begin
      do_ack();
      do_ret();
      @(negedge clk);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 req", int'(req_o), 0);
    check("R1 vec", int'(vec_o), 0);
    check("R1 lvl", int'(lvl_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk
    for (int r = 0; r < 8; r++) begin
      lvl_sel_i = TBL[r].sel;
      pulse_irq(TBL[r].irq);
      @(negedge clk);
      check($sformatf("R4/R5 row%0d req", r), int'(req_o), 1);
      check($sformatf("R2 row%0d vec", r), int'(vec_o), int'(TBL[r].vec));
      check($sformatf("R3 row%0d lvl", r), int'(lvl_o), int'(TBL[r].lvl));
      drain();
    end
    lvl_sel_i = '0;

    // R11 latency
    irq_i = 10'h020;
    @(negedge clk);
    irq_i = '0;
    check("R11 not yet", int'(req_o), 0);
    @(negedge clk);
    check("R11 shown", int'(req_o), 1);
    drain();

    // R7 disabled line keeps pending
    en_i = ~10'h020;
    pulse_irq(10'h020);
    repeat (3) @(negedge clk);
    check("R7 disabled", int'(req_o), 0);
    en_i = '1;
    @(negedge clk);
    check("R7 enabled req", int'(req_o), 1);
    check("R7 enabled vec", int'(vec_o), 8'h2B);
    drain();

    // R6 pending holds, ack clears; R10 hold on ack
    pulse_irq(10'h040);
    repeat (5) @(negedge clk);
    check("R6 held", int'(req_o), 1);
    check("R6 vec", int'(vec_o), 8'h33);
    do_ack();
    check("R10 req drops", int'(req_o), 0);
    check("R10 vec held", int'(vec_o), 8'h33);
    @(negedge clk);
    check("R6 cleared", int'(req_o), 0);
    do_ret();

    // R8/R9 nesting
    lvl_sel_i = 10'h051;
    pulse_irq(10'h010);
    @(negedge clk);
    check("R8 first high", int'(vec_o), 8'h23);
    do_ack();
    pulse_irq(10'h044);
    @(negedge clk);
    check("R8 equal/lower refused", int'(req_o), 0);
    pulse_irq(10'h001);
    @(negedge clk);
    check("R8 highest accepted", int'(vec_o), 8'h03);
    check("R8 highest lvl", int'(lvl_o), 2);
    do_ack();
    do_ret();
    @(negedge clk);
    check("R9 still high in service", int'(req_o), 0);
    do_ret();
    @(negedge clk);
    check("R9 released req", int'(req_o), 1);
    check("R9 released vec", int'(vec_o), 8'h33);
    check("R9 released lvl", int'(lvl_o), 1);
    drain();
    lvl_sel_i = '0;

    // R10 idle ack, R9 idle ret have no effect
    do_ack();
    do_ret();
    pulse_irq(10'h008);
    @(negedge clk);
    check("R10 idle ack ignored", int'(req_o), 1);
    check("R10 idle ack vec", int'(vec_o), 8'h1B);
    drain();

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule